// File: doc/BRIEF.md
# Scoreboard Hazard Control Unit

This block is the central control of an out-of-order scheduling scheme built on stalls. It follows every instruction in flight across a small set of non-pipelined functional units: a parameterized number of adders, one multiplier and one divider. Each instruction goes through issue, operand read, execution and write-back, in that order. Each kind of hazard is settled by stalling at its own step. Structural conflicts and output conflicts hold issue. True data conflicts hold operand read. Anti-dependences hold write-back. No register is renamed.

A decoder presents one instruction per cycle, with a class, a destination and two sources. The scoreboard accepts it when `in_valid_i` and `in_ready_o` are both high, and it picks the unit. After that the scoreboard tells each unit when its operands may be fetched from the register file. Each unit reports the end of its execution with a one-cycle pulse. The scoreboard then grants the single register-file write port to one finished unit per cycle.

Internally the block keeps three records. Per unit it holds a step and a status entry: destination, source registers, producer unit of each source and a ready flag per source. Per architectural register it holds the unit that will write it.

Top module: `sb_scoreboard`

## Requirements
- R1: `in_ready_o` is combinational and independent of `in_valid_i`. An instruction is issued on a rising clock edge where `in_valid_i` and `in_ready_o` are both high. Class code 0 is add, 1 is multiply, 2 is divide. Class code 3 has no unit, so it never gives `in_ready_o`.
- R2: Units 0 to NUM_ADD-1 are adders, unit NUM_ADD is the multiplier and unit NUM_ADD+1 is the divider. `issue_fu_o` names the lowest-numbered free unit of the requested class.
- R3: `in_ready_o` is low while every unit of the requested class is busy (structural hazard).
- R4: `in_ready_o` is low while any active instruction still has to write the requested destination (output hazard), even if a unit is free.
- R5: Bit i of `rd_go_o` is high while unit i waits in the operand-read step and both of its sources are ready. A source is not ready while an earlier unfinished instruction is to write it. It becomes ready in the cycle after that producer's write-back edge. During `rd_go_o[i]`, the slices for unit i of `rd_addr1_o`/`rd_addr2_o` carry its source registers. The read edge moves the unit to execution.
- R6: An instruction issued on the same edge as the write-back of its source's producer treats that source as ready. It reads in the next cycle.
- R7: A `fu_done_i` pulse moves a unit from execution to the finished step. In any other step the pulse is ignored.
- R8: A finished unit is not granted write-back while another unit still in the operand-read step has a ready source equal to the finished unit's destination (anti-dependence).
- R9: At most one write-back per cycle, granted to the lowest-numbered eligible finished unit. `rf_we_o`, `rf_waddr_o` and `wb_fu_o` are combinational. The write edge frees the unit and clears the pending write on its destination.
- R10: After reset no unit is busy and no register has a pending writer. `rd_go_o` and `rf_we_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| in_valid_i | input | 1 | Decoded instruction present |
| in_cls_i | input | 2 | Unit class: 0 add, 1 multiply, 2 divide, 3 none |
| in_dst_i | input | $clog2(NUM_REG) | Destination register |
| in_src1_i | input | $clog2(NUM_REG) | First source register |
| in_src2_i | input | $clog2(NUM_REG) | Second source register |
| in_ready_o | output | 1 | Instruction may issue this cycle |
| issue_fu_o | output | $clog2(NUM_ADD+2) | Unit that takes the instruction |
| rd_go_o | output | NUM_ADD+2 | Per-unit operand-read grant |
| rd_addr1_o | output | (NUM_ADD+2)*$clog2(NUM_REG) | Per-unit first source address |
| rd_addr2_o | output | (NUM_ADD+2)*$clog2(NUM_REG) | Per-unit second source address |
| fu_done_i | input | NUM_ADD+2 | Per-unit end-of-execution pulse |
| rf_we_o | output | 1 | Register-file write enable |
| rf_waddr_o | output | $clog2(NUM_REG) | Register-file write address |
| wb_fu_o | output | $clog2(NUM_ADD+2) | Unit whose result is written |

## Verification
The issue decision and the write grant are combinational. The bench samples them in the same cycle as the stimulus, one time unit after it drives the inputs on the falling edge. An operand-read grant shows up in the cycle after the issue edge, or in the cycle after the producer's write edge. A write grant shows up in the cycle after the edge that latched the done pulse. Every task ends just after a falling edge, so each check lands in the cycle where the result is due and never on a rising edge.

// File: rtl/sb_pkg.sv
package sb_pkg;

  typedef enum logic [1:0] {
    CLS_ADD  = 2'd0,
    CLS_MUL  = 2'd1,
    CLS_DIV  = 2'd2,
    CLS_NONE = 2'd3
  } fu_cls_e;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_WAIT = 2'd1,
    PH_EXEC = 2'd2,
    PH_DONE = 2'd3
  } phase_e;

  function automatic fu_cls_e unit_cls(input int unsigned idx, input int unsigned n_add);
    if (idx < n_add)       return CLS_ADD;
    else if (idx == n_add) return CLS_MUL;
    else                   return CLS_DIV;
  endfunction

endpackage

// File: rtl/sb_issue_ctl.sv
module sb_issue_ctl #(
  parameter int unsigned NUM_ADD = 2,
  parameter int unsigned NUM_FU  = NUM_ADD + 2,
  parameter int unsigned FU_W    = $clog2(NUM_FU)
) (
  input  logic [1:0]        cls_i,
  input  logic              dst_pend_i,
  input  logic [NUM_FU-1:0] busy_i,
  output logic              ready_o,
  output logic [FU_W-1:0]   fu_o
);

  logic [NUM_FU-1:0] cls_hit;
  logic [NUM_FU-1:0] free;

  for (genvar g = 0; g < NUM_FU; g++) begin : g_cls
    assign cls_hit[g] = (cls_i == 2'(sb_pkg::unit_cls(g, NUM_ADD)));
  end

  assign free = cls_hit & ~busy_i;

  always_comb begin
    fu_o = '0;
    for (int i = NUM_FU - 1; i >= 0; i--) begin
      if (free[i]) fu_o = FU_W'(i);
    end
  end

  assign ready_o = (|free) && !dst_pend_i;

endmodule

// File: rtl/sb_reg_status.sv
module sb_reg_status #(
  parameter int unsigned NUM_REG = 8,
  parameter int unsigned FU_W    = 2,
  parameter int unsigned REG_W   = $clog2(NUM_REG)
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           set_i,
  input  logic [REG_W-1:0]               set_reg_i,
  input  logic [FU_W-1:0]                set_fu_i,
  input  logic                           wb_i,
  input  logic [REG_W-1:0]               wb_reg_i,
  input  logic [FU_W-1:0]                wb_fu_i,
  input  logic [REG_W-1:0]               dst_i,
  input  logic [REG_W-1:0]               src1_i,
  input  logic [REG_W-1:0]               src2_i,
  output logic                           dst_pend_o,
  output logic                           rdy1_o,
  output logic [FU_W-1:0]                q1_o,
  output logic                           rdy2_o,
  output logic [FU_W-1:0]                q2_o,
  output logic [NUM_REG-1:0]             prod_v_o,
  output logic [NUM_REG-1:0][FU_W-1:0]   prod_fu_o
);

  logic [NUM_REG-1:0]           prod_v_q;
  logic [NUM_REG-1:0][FU_W-1:0] prod_fu_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prod_v_q  <= '0;
      prod_fu_q <= '0;
    end else begin
      for (int r = 0; r < NUM_REG; r++) begin
        if (wb_i && wb_reg_i == REG_W'(r)) prod_v_q[r] <= 1'b0;
        if (set_i && set_reg_i == REG_W'(r)) begin
          prod_v_q[r]  <= 1'b1;
          prod_fu_q[r] <= set_fu_i;
        end
      end
    end
  end

  // a producer finishing on this edge counts as ready
  assign q1_o   = prod_fu_q[src1_i];
  assign q2_o   = prod_fu_q[src2_i];
  assign rdy1_o = !prod_v_q[src1_i] || (wb_i && wb_fu_i == q1_o);
  assign rdy2_o = !prod_v_q[src2_i] || (wb_i && wb_fu_i == q2_o);

  assign dst_pend_o = prod_v_q[dst_i];
  assign prod_v_o   = prod_v_q;
  assign prod_fu_o  = prod_fu_q;

endmodule

// File: rtl/sb_fu_entry.sv
module sb_fu_entry #(
  parameter int unsigned REG_W = 3,
  parameter int unsigned FU_W  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              issue_i,
  input  logic [REG_W-1:0]  dst_i,
  input  logic [REG_W-1:0]  src1_i,
  input  logic [REG_W-1:0]  src2_i,
  input  logic              rdy1_i,
  input  logic [FU_W-1:0]   q1_i,
  input  logic              rdy2_i,
  input  logic [FU_W-1:0]   q2_i,
  input  logic              wb_i,
  input  logic [FU_W-1:0]   wb_fu_i,
  input  logic              wb_self_i,
  input  logic              done_i,
  output sb_pkg::phase_e    phase_o,
  output logic [REG_W-1:0]  fi_o,
  output logic [REG_W-1:0]  fj_o,
  output logic [REG_W-1:0]  fk_o,
  output logic              rj_o,
  output logic              rk_o,
  output logic              rd_go_o
);

  import sb_pkg::*;

  phase_e           phase_q;
  logic [REG_W-1:0] fi_q, fj_q, fk_q;
  logic [FU_W-1:0]  qj_q, qk_q;
  logic             rj_q, rk_q;

  assign rd_go_o = (phase_q == PH_WAIT) && rj_q && rk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      fi_q    <= '0;
      fj_q    <= '0;
      fk_q    <= '0;
      qj_q    <= '0;
      qk_q    <= '0;
      rj_q    <= 1'b0;
      rk_q    <= 1'b0;
    end else begin
      unique case (phase_q)
        PH_IDLE: if (issue_i) begin
          phase_q <= PH_WAIT;
          fi_q    <= dst_i;
          fj_q    <= src1_i;
          fk_q    <= src2_i;
          qj_q    <= q1_i;
          qk_q    <= q2_i;
          rj_q    <= rdy1_i;
          rk_q    <= rdy2_i;
        end
        PH_WAIT: begin
          if (rd_go_o) begin
            phase_q <= PH_EXEC;
            rj_q    <= 1'b0;
            rk_q    <= 1'b0;
          end else begin
            if (wb_i && !rj_q && qj_q == wb_fu_i) rj_q <= 1'b1;
            if (wb_i && !rk_q && qk_q == wb_fu_i) rk_q <= 1'b1;
          end
        end
        PH_EXEC: if (done_i) phase_q <= PH_DONE;
        PH_DONE: if (wb_self_i) phase_q <= PH_IDLE;
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign phase_o = phase_q;
  assign fi_o    = fi_q;
  assign fj_o    = fj_q;
  assign fk_o    = fk_q;
  assign rj_o    = rj_q;
  assign rk_o    = rk_q;

endmodule

// File: rtl/sb_wb_arb.sv
module sb_wb_arb #(
  parameter int unsigned NUM_FU = 4,
  parameter int unsigned REG_W  = 3,
  parameter int unsigned FU_W   = 2
) (
  input  logic [NUM_FU-1:0]            wait_i,
  input  logic [NUM_FU-1:0]            done_i,
  input  logic [NUM_FU-1:0][REG_W-1:0] fi_i,
  input  logic [NUM_FU-1:0][REG_W-1:0] fj_i,
  input  logic [NUM_FU-1:0][REG_W-1:0] fk_i,
  input  logic [NUM_FU-1:0]            rj_i,
  input  logic [NUM_FU-1:0]            rk_i,
  output logic [NUM_FU-1:0]            grant_o,
  output logic                         valid_o,
  output logic [FU_W-1:0]              fu_o,
  output logic [REG_W-1:0]             reg_o
);

  logic [NUM_FU-1:0] war;
  logic [NUM_FU-1:0] cand;

  // a pending reader of the old value blocks the write
  always_comb begin
    war = '0;
    for (int w = 0; w < NUM_FU; w++) begin
      for (int u = 0; u < NUM_FU; u++) begin
        if (u != w && wait_i[u] &&
            ((rj_i[u] && fj_i[u] == fi_i[w]) || (rk_i[u] && fk_i[u] == fi_i[w])))
          war[w] = 1'b1;
      end
    end
  end

  assign cand = done_i & ~war;

  always_comb begin
    fu_o = '0;
    for (int i = NUM_FU - 1; i >= 0; i--) begin
      if (cand[i]) fu_o = FU_W'(i);
    end
  end

  assign valid_o = |cand;
  assign grant_o = valid_o ? (NUM_FU'(1) << fu_o) : '0;
  assign reg_o   = fi_i[fu_o];

endmodule

// File: rtl/sb_scoreboard.sv
module sb_scoreboard #(
  parameter int unsigned NUM_ADD = 2,
  parameter int unsigned NUM_REG = 8,
  localparam int unsigned NUM_FU = NUM_ADD + 2,
  localparam int unsigned FU_W   = $clog2(NUM_FU),
  localparam int unsigned REG_W  = $clog2(NUM_REG)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      in_valid_i,
  input  logic [1:0]                in_cls_i,
  input  logic [REG_W-1:0]          in_dst_i,
  input  logic [REG_W-1:0]          in_src1_i,
  input  logic [REG_W-1:0]          in_src2_i,
  output logic                      in_ready_o,
  output logic [FU_W-1:0]           issue_fu_o,
  output logic [NUM_FU-1:0]         rd_go_o,
  output logic [NUM_FU*REG_W-1:0]   rd_addr1_o,
  output logic [NUM_FU*REG_W-1:0]   rd_addr2_o,
  input  logic [NUM_FU-1:0]         fu_done_i,
  output logic                      rf_we_o,
  output logic [REG_W-1:0]          rf_waddr_o,
  output logic [FU_W-1:0]           wb_fu_o
);

  import sb_pkg::*;

  logic                          accept;
  logic                          dst_pend;
  logic                          rdy1, rdy2;
  logic [FU_W-1:0]               q1, q2;
  logic [NUM_REG-1:0]            prod_v;
  logic [NUM_REG-1:0][FU_W-1:0]  prod_fu;

  logic [NUM_FU-1:0]             busy_v, wait_v, exec_v, done_v;
  logic [NUM_FU-1:0][REG_W-1:0]  fi, fj, fk;
  logic [NUM_FU-1:0]             rj_v, rk_v;
  logic [NUM_FU-1:0]             wb_grant;
  logic                          wb_valid;
  logic [REG_W-1:0]              wb_reg;

  assign accept = in_valid_i && in_ready_o;

  sb_issue_ctl #(.NUM_ADD(NUM_ADD), .NUM_FU(NUM_FU), .FU_W(FU_W)) i_issue (
    .cls_i      (in_cls_i),
    .dst_pend_i (dst_pend),
    .busy_i     (busy_v),
    .ready_o    (in_ready_o),
    .fu_o       (issue_fu_o)
  );

  sb_reg_status #(.NUM_REG(NUM_REG), .FU_W(FU_W), .REG_W(REG_W)) i_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .set_i      (accept),
    .set_reg_i  (in_dst_i),
    .set_fu_i   (issue_fu_o),
    .wb_i       (wb_valid),
    .wb_reg_i   (wb_reg),
    .wb_fu_i    (wb_fu_o),
    .dst_i      (in_dst_i),
    .src1_i     (in_src1_i),
    .src2_i     (in_src2_i),
    .dst_pend_o (dst_pend),
    .rdy1_o     (rdy1),
    .q1_o       (q1),
    .rdy2_o     (rdy2),
    .q2_o       (q2),
    .prod_v_o   (prod_v),
    .prod_fu_o  (prod_fu)
  );

  for (genvar g = 0; g < NUM_FU; g++) begin : g_fu
    phase_e ph;

    sb_fu_entry #(.REG_W(REG_W), .FU_W(FU_W)) i_entry (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .issue_i   (accept && issue_fu_o == FU_W'(g)),
      .dst_i     (in_dst_i),
      .src1_i    (in_src1_i),
      .src2_i    (in_src2_i),
      .rdy1_i    (rdy1),
      .q1_i      (q1),
      .rdy2_i    (rdy2),
      .q2_i      (q2),
      .wb_i      (wb_valid),
      .wb_fu_i   (wb_fu_o),
      .wb_self_i (wb_grant[g]),
      .done_i    (fu_done_i[g]),
      .phase_o   (ph),
      .fi_o      (fi[g]),
      .fj_o      (fj[g]),
      .fk_o      (fk[g]),
      .rj_o      (rj_v[g]),
      .rk_o      (rk_v[g]),
      .rd_go_o   (rd_go_o[g])
    );

    assign busy_v[g] = (ph != PH_IDLE);
    assign wait_v[g] = (ph == PH_WAIT);
    assign exec_v[g] = (ph == PH_EXEC);
    assign done_v[g] = (ph == PH_DONE);
    assign rd_addr1_o[g*REG_W +: REG_W] = fj[g];
    assign rd_addr2_o[g*REG_W +: REG_W] = fk[g];
  end

  sb_wb_arb #(.NUM_FU(NUM_FU), .REG_W(REG_W), .FU_W(FU_W)) i_wb (
    .wait_i  (wait_v),
    .done_i  (done_v),
    .fi_i    (fi),
    .fj_i    (fj),
    .fk_i    (fk),
    .rj_i    (rj_v),
    .rk_i    (rk_v),
    .grant_o (wb_grant),
    .valid_o (wb_valid),
    .fu_o    (wb_fu_o),
    .reg_o   (wb_reg)
  );

  assign rf_we_o    = wb_valid;
  assign rf_waddr_o = wb_reg;

endmodule

// File: rtl/sb_scoreboard_chk.sv
module sb_scoreboard_chk #(
  parameter int unsigned NUM_FU  = 4,
  parameter int unsigned NUM_REG = 8,
  parameter int unsigned FU_W    = 2,
  parameter int unsigned REG_W   = 3
) (
  input logic                          clk_i,
  input logic                          rst_ni,
  input logic                          accept,
  input logic [REG_W-1:0]              in_dst_i,
  input logic [FU_W-1:0]               issue_fu_o,
  input logic [NUM_FU-1:0]             busy_v,
  input logic [NUM_FU-1:0]             wait_v,
  input logic [NUM_FU-1:0]             exec_v,
  input logic [NUM_FU-1:0]             done_v,
  input logic [NUM_FU-1:0]             rj_v,
  input logic [NUM_FU-1:0]             rk_v,
  input logic [NUM_FU-1:0][REG_W-1:0]  fj,
  input logic [NUM_FU-1:0][REG_W-1:0]  fk,
  input logic [NUM_REG-1:0]            prod_v,
  input logic [NUM_REG-1:0][FU_W-1:0]  prod_fu,
  input logic [NUM_FU-1:0]             rd_go_o,
  input logic [NUM_FU-1:0]             fu_done_i,
  input logic [NUM_FU-1:0]             wb_grant,
  input logic                          rf_we_o,
  input logic [REG_W-1:0]              rf_waddr_o
);

  p_issue_free_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |-> !busy_v[issue_fu_o]);

  p_dst_claimed_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> prod_v[$past(in_dst_i)] && prod_fu[$past(in_dst_i)] == $past(issue_fu_o));

  for (genvar g = 0; g < NUM_FU; g++) begin : g_chk
    p_read_exec_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rd_go_o[g] |=> exec_v[g]);

    p_done_wait_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (fu_done_i[g] && wait_v[g] && !rd_go_o[g]) |=> wait_v[g]);

    p_done_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (fu_done_i[g] && !busy_v[g]) |=> !done_v[g]);

    p_war_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rf_we_o && wait_v[g]) |->
        !((rj_v[g] && fj[g] == rf_waddr_o) || (rk_v[g] && fk[g] == rf_waddr_o)));

    p_wb_src_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wb_grant[g] |-> done_v[g]);

    p_wb_free_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wb_grant[g] |=> !busy_v[g]);
  end

endmodule

bind sb_scoreboard sb_scoreboard_chk #(
  .NUM_FU (NUM_FU),
  .NUM_REG(NUM_REG),
  .FU_W   (FU_W),
  .REG_W  (REG_W)
) i_sb_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .accept     (accept),
  .in_dst_i   (in_dst_i),
  .issue_fu_o (issue_fu_o),
  .busy_v     (busy_v),
  .wait_v     (wait_v),
  .exec_v     (exec_v),
  .done_v     (done_v),
  .rj_v       (rj_v),
  .rk_v       (rk_v),
  .fj         (fj),
  .fk         (fk),
  .prod_v     (prod_v),
  .prod_fu    (prod_fu),
  .rd_go_o    (rd_go_o),
  .fu_done_i  (fu_done_i),
  .wb_grant   (wb_grant),
  .rf_we_o    (rf_we_o),
  .rf_waddr_o (rf_waddr_o)
);

// File: tb/test_sb_scoreboard.sv
module test_sb_scoreboard;

  localparam int CLK_PERIOD = 10;
  localparam int NUM_ADD = 2;
  localparam int NUM_REG = 8;
  localparam int NUM_FU  = NUM_ADD + 2;
  localparam int FU_W    = $clog2(NUM_FU);
  localparam int REG_W   = $clog2(NUM_REG);
  localparam int LAT_ADD = 2;
  localparam int LAT_MUL = 4;
  localparam int N_VEC   = 8;

  // {a_cls, a_dst, b_cls, b_dst, b_src, exp_ready, exp_fu}
  localparam logic [15:0] VEC [N_VEC] = '{
    {2'd0, 3'd1, 2'd0, 3'd2, 3'd0, 1'b1, 2'd1},  // second adder free
    {2'd1, 3'd1, 2'd1, 3'd2, 3'd0, 1'b0, 2'd0},  // multiplier busy
    {2'd0, 3'd1, 2'd1, 3'd1, 3'd0, 1'b0, 2'd0},  // same destination
    {2'd2, 3'd3, 2'd0, 3'd4, 3'd3, 1'b1, 2'd0},  // pending source does not stop issue
    {2'd1, 3'd2, 2'd2, 3'd5, 3'd0, 1'b1, 2'd3},  // divider free
    {2'd0, 3'd1, 2'd3, 3'd2, 3'd0, 1'b0, 2'd0},  // class without unit
    {2'd2, 3'd1, 2'd2, 3'd2, 3'd0, 1'b0, 2'd0},  // divider busy
    {2'd0, 3'd5, 2'd0, 3'd5, 3'd0, 1'b0, 2'd0}   // same destination, adder free
  };

  logic                     clk_i = 1'b0;
  logic                     rst_ni = 1'b0;
  logic                     in_valid_i = 1'b0;
  logic [1:0]               in_cls_i = '0;
  logic [REG_W-1:0]         in_dst_i = '0;
  logic [REG_W-1:0]         in_src1_i = '0;
  logic [REG_W-1:0]         in_src2_i = '0;
  logic                     in_ready_o;
  logic [FU_W-1:0]          issue_fu_o;
  logic [NUM_FU-1:0]        rd_go_o;
  logic [NUM_FU*REG_W-1:0]  rd_addr1_o;
  logic [NUM_FU*REG_W-1:0]  rd_addr2_o;
  logic [NUM_FU-1:0]        fu_done_i = '0;
  logic                     rf_we_o;
  logic [REG_W-1:0]         rf_waddr_o;
  logic [FU_W-1:0]          wb_fu_o;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  sb_scoreboard #(.NUM_ADD(NUM_ADD), .NUM_REG(NUM_REG)) i_sb_scoreboard (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .in_valid_i (in_valid_i),
    .in_cls_i   (in_cls_i),
    .in_dst_i   (in_dst_i),
    .in_src1_i  (in_src1_i),
    .in_src2_i  (in_src2_i),
    .in_ready_o (in_ready_o),
    .issue_fu_o (issue_fu_o),
    .rd_go_o    (rd_go_o),
    .rd_addr1_o (rd_addr1_o),
    .rd_addr2_o (rd_addr2_o),
    .fu_done_i  (fu_done_i),
    .rf_we_o    (rf_we_o),
    .rf_waddr_o (rf_waddr_o),
    .wb_fu_o    (wb_fu_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk_i);
    #1;
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    in_valid_i = 1'b0;
    fu_done_i = '0;
    tick();
    tick();
    rst_ni = 1'b1;
    #1;
  endtask

  task automatic put(input logic [1:0] cls, input int dst, input int s1, input int s2,
                     output logic rdy, output int fu);
    in_cls_i   = cls;
    in_dst_i   = REG_W'(dst);
    in_src1_i  = REG_W'(s1);
    in_src2_i  = REG_W'(s2);
    in_valid_i = 1'b1;
    #1;
    rdy = in_ready_o;
    fu  = int'(issue_fu_o);
    @(negedge clk_i);
    in_valid_i = 1'b0;
    #1;
  endtask

  task automatic pulse(input logic [NUM_FU-1:0] m);
    fu_done_i = m;
    tick();
    fu_done_i = '0;
    #1;
  endtask

  function automatic int first_unit(input logic [1:0] cls);
    if (cls == 2'd0) return 0;
    if (cls == 2'd1) return NUM_ADD;
    return NUM_ADD + 1;
  endfunction

  initial begin
    logic rdy;
    int fu;

    // R10: reset state
    do_reset();
    in_cls_i = 2'd0;
    in_dst_i = '0;
    #1;
    chk("R10 ready after reset", int'(in_ready_o), 1);
    chk("R10 no read grant", int'(rd_go_o), 0);
    chk("R10 no write", int'(rf_we_o), 0);

    // R7: done pulses on idle units are ignored
    pulse('1);
    chk("R7 idle done ignored", int'(rf_we_o), 0);

    // R1 R2 R3 R4: issue vector table
    for (int v = 0; v < N_VEC; v++) begin
      logic [15:0] e;
      e = VEC[v];
      do_reset();
      in_cls_i  = e[15:14];
      in_dst_i  = e[13:11];
      in_src1_i = 3'd7;
      in_src2_i = 3'd7;
      in_valid_i = 1'b1;
      #1;
      chk("R1 first issue ready", int'(in_ready_o), 1);
      chk("R2 first unit of class", int'(issue_fu_o), first_unit(e[15:14]));
      @(negedge clk_i);
      in_cls_i  = e[10:9];
      in_dst_i  = e[8:6];
      in_src1_i = e[5:3];
      in_src2_i = e[5:3];
      #1;
      chk("R3 R4 second issue ready", int'(in_ready_o), int'(e[2]));
      if (e[2]) chk("R2 second unit choice", int'(issue_fu_o), int'(e[1:0]));
      in_valid_i = 1'b0;
    end

    // R5: operand read waits for producer write-back
    do_reset();
    #1;
    put(2'd1, 1, 2, 3, rdy, fu);
    chk("R5 mul read grant", int'(rd_go_o[2]), 1);
    chk("R5 mul src1 address", int'(rd_addr1_o[2*REG_W +: REG_W]), 2);
    chk("R5 mul src2 address", int'(rd_addr2_o[2*REG_W +: REG_W]), 3);
    put(2'd0, 4, 1, 5, rdy, fu);
    chk("R1 dependent add issued", int'(rdy), 1);
    chk("R5 add waits on r1", int'(rd_go_o[0]), 0);
    repeat (LAT_MUL - 1) tick();
    chk("R5 still waiting", int'(rd_go_o[0]), 0);
    pulse(4'b0100);
    chk("R9 mul write enable", int'(rf_we_o), 1);
    chk("R9 mul write address", int'(rf_waddr_o), 1);
    chk("R9 mul write unit", int'(wb_fu_o), 2);
    chk("R5 add not yet read", int'(rd_go_o[0]), 0);
    tick();
    chk("R5 add read after write-back", int'(rd_go_o[0]), 1);
    chk("R9 single write", int'(rf_we_o), 0);
    put(2'd1, 1, 0, 0, rdy, fu);
    chk("R9 unit and dst freed", int'(rdy), 1);
    chk("R2 mul unit reused", fu, 2);

    // R6: issue on the producer's write-back edge
    do_reset();
    #1;
    put(2'd1, 1, 2, 2, rdy, fu);
    tick();
    pulse(4'b0100);
    chk("R9 write pending", int'(rf_we_o), 1);
    put(2'd0, 2, 1, 1, rdy, fu);
    chk("R6 issued in write cycle", int'(rdy), 1);
    chk("R6 bypass read grant", int'(rd_go_o[0]), 1);

    // R8 R7: anti-dependence hold and done in wait step
    do_reset();
    #1;
    put(2'd1, 5, 6, 7, rdy, fu);
    put(2'd2, 3, 5, 4, rdy, fu);
    put(2'd0, 4, 1, 1, rdy, fu);
    chk("R5 add read grant", int'(rd_go_o[0]), 1);
    chk("R5 div waits on r5", int'(rd_go_o[3]), 0);
    repeat (LAT_ADD - 1) tick();
    pulse(4'b0001);
    chk("R8 add write held", int'(rf_we_o), 0);
    pulse(4'b1000);
    chk("R7 done in wait ignored", int'(rf_we_o), 0);
    chk("R7 div still waiting", int'(rd_go_o[3]), 0);
    pulse(4'b0100);
    chk("R8 mul write allowed", int'(rf_we_o), 1);
    chk("R8 mul write unit", int'(wb_fu_o), 2);
    chk("R8 mul write address", int'(rf_waddr_o), 5);
    tick();
    chk("R5 div read grant", int'(rd_go_o[3]), 1);
    chk("R8 add held during read", int'(rf_we_o), 0);
    tick();
    chk("R8 add write released", int'(rf_we_o), 1);
    chk("R8 add write unit", int'(wb_fu_o), 0);
    chk("R8 add write address", int'(rf_waddr_o), 4);

    // R9: simultaneous completions, lowest unit first
    do_reset();
    #1;
    put(2'd0, 1, 0, 0, rdy, fu);
    put(2'd0, 2, 0, 0, rdy, fu);
    tick();
    pulse(4'b0011);
    chk("R9 first writer unit", int'(wb_fu_o), 0);
    chk("R9 first writer address", int'(rf_waddr_o), 1);
    tick();
    chk("R9 second writer enable", int'(rf_we_o), 1);
    chk("R9 second writer unit", int'(wb_fu_o), 1);
    chk("R9 second writer address", int'(rf_waddr_o), 2);
    tick();
    chk("R9 writes drained", int'(rf_we_o), 0);

    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule